// File: doc/BRIEF.md
# Charge Level Counter

This block holds the remaining charge of a battery as a 16-bit count, made of a high byte and a low byte. Charge pulses raise the count and discharge or self-discharge pulses lower it. A charge pulse first passes through an efficiency stage, which is a fractional accumulator. The accumulator adds a step constant on each charge pulse and moves the count up by one only when it overflows. The fast-charge select picks one of two step constants: one for fast charge and one for trickle charge.

A host reaches the counter over a small register port. The high byte can be read and written. The low byte can only be read. The low byte holds its value while the high byte is zero, so the count never falls below zero. A valid-charge strobe clears the low byte. A host write to the high byte wins over any count pulse in the same cycle.

Top module: `chg_level_counter`

## Requirements
- R1: A synchronous reset sets both bytes, the efficiency accumulator and the read data to zero. The reset takes effect on the first rising edge at which `rst` is high.
- R2: Each of `dsg_pulse` and `sdsg_pulse` lowers the count by one. When both are high in the same cycle, the count drops by two.
- R3: A charge pulse adds the step to an 8-bit fractional accumulator. The step is 243 when `fast_sel` is 1 and 192 when `fast_sel` is 0. When the sum is 256 or more, the count rises by one and the accumulator keeps the sum minus 256.
- R4: A write with `wr_en` high and `reg_addr` equal to 0x03 loads `wdata` into the high byte on the next edge. The low byte is left unchanged.
- R5: A write to address 0x17 (the low byte) has no effect on either byte. In that cycle, count pulses act as usual.
- R6: While the high byte is zero, discharge and self-discharge pulses are ignored, so the low byte does not change. Charge pulses still count.
- R7: A pulse on `valid_chg` clears the low byte and keeps the high byte.
- R8: At a count of 0xFFFF, an increment from the accumulator is dropped. The accumulator still advances. A decrement in the same cycle still applies.
- R9: In a cycle that holds a high-byte write or `valid_chg`, all count pulses are dropped and the accumulator keeps its value.
- R10: A read with `rd_en` high loads `rd_data` on the next edge. Address 0x03 returns the high byte and address 0x17 returns the low byte, both as they were before that edge. Any other address returns 0. Without `rd_en`, `rd_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chg_pulse | input | 1 | Charge count strobe |
| dsg_pulse | input | 1 | Discharge count strobe |
| sdsg_pulse | input | 1 | Self-discharge count strobe |
| valid_chg | input | 1 | Valid charge detected, clears the low byte |
| fast_sel | input | 1 | 1 picks the fast-charge step, 0 the trickle step |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| hi_byte | output | 8 | High byte of the count |
| lo_byte | output | 8 | Low byte of the count |

## Verification
The assertions assume that every input is a known value on each rising edge. They also assume that `rst` is held for at least one edge before any strobe is trusted. Each strobe is treated as a single-cycle event that is sampled on the edge where it is high. The stimulus drives every input on the falling edge and leaves it there for exactly one full cycle. It never leaves a strobe in an unknown state. Writes, valid-charge strobes and count pulses are made to meet in the same cycle only on purpose, to check which one takes priority.

// File: rtl/chg_pkg.sv
package chg_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = 2 * BYTE_W;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  typedef struct packed {
    logic wr_hi;
    logic wr_lo;
    logic rd_hi;
    logic rd_lo;
  } dec_t;
endpackage

// File: rtl/chg_eff_weight.sv
module chg_eff_weight #(
  parameter int unsigned FRAC_W       = 8,
  parameter int unsigned FAST_STEP    = 243,
  parameter int unsigned TRICKLE_STEP = 192
) (
  input  logic clk,
  input  logic rst,
  input  logic chg_pulse,
  input  logic hold,
  input  logic fast_sel,
  output logic carry
);
  localparam int unsigned SUM_W = FRAC_W + 1;
  localparam logic [FRAC_W-1:0] FAST_K    = FAST_STEP[FRAC_W-1:0];
  localparam logic [FRAC_W-1:0] TRICKLE_K = TRICKLE_STEP[FRAC_W-1:0];

  logic [FRAC_W-1:0] frac_q;
  logic [FRAC_W-1:0] step;
  logic [SUM_W-1:0]  sum;
  logic              adv;

  assign step  = fast_sel ? FAST_K : TRICKLE_K;
  assign sum   = {1'b0, frac_q} + {1'b0, step};
  assign adv   = chg_pulse & ~hold;
  assign carry = adv & sum[FRAC_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      frac_q <= '0;
    end else if (adv) begin
      frac_q <= sum[FRAC_W-1:0];
    end
  end
endmodule

// File: rtl/chg_acc_core.sv
module chg_acc_core
  import chg_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  inc,
  input  logic  dsg_pulse,
  input  logic  sdsg_pulse,
  input  logic  wr_hi,
  input  logic  clr_lo,
  input  byte_t wdata,
  output byte_t hi_q,
  output byte_t lo_q
);
  localparam int unsigned EXT_W = CNT_W + 2;
  localparam cnt_t CNT_MAX = '1;

  cnt_t             cnt;
  logic             hi_zero;
  logic [1:0]       dec_n;
  logic             inc_ok;
  logic [EXT_W-1:0] next_ext;
  logic             hold;

  assign cnt      = {hi_q, lo_q};
  assign hi_zero  = (hi_q == '0);
  assign hold     = wr_hi | clr_lo;
  assign dec_n    = hi_zero ? 2'd0 : ({1'b0, dsg_pulse} + {1'b0, sdsg_pulse});
  assign inc_ok   = inc & (cnt != CNT_MAX);
  assign next_ext = {2'b00, cnt} + {{(EXT_W-1){1'b0}}, inc_ok}
                    - {{(EXT_W-2){1'b0}}, dec_n};

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (hold) begin
      if (wr_hi)  hi_q <= wdata;
      if (clr_lo) lo_q <= '0;
    end else begin
      hi_q <= next_ext[CNT_W-1:BYTE_W];
      lo_q <= next_ext[BYTE_W-1:0];
    end
  end
endmodule

// File: rtl/chg_reg_port.sv
module chg_reg_port
  import chg_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned HI_ADDR = 8'h03,
  parameter int unsigned LO_ADDR = 8'h17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  byte_t             hi_q,
  input  byte_t             lo_q,
  output logic              wr_hi,
  output byte_t             rd_data
);
  localparam logic [ADDR_W-1:0] HI_A = HI_ADDR[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] LO_A = LO_ADDR[ADDR_W-1:0];

  dec_t  dec;
  byte_t rd_mux;

  always_comb begin
    dec.wr_hi = wr_en & (reg_addr == HI_A);
    dec.wr_lo = wr_en & (reg_addr == LO_A);
    dec.rd_hi = rd_en & (reg_addr == HI_A);
    dec.rd_lo = rd_en & (reg_addr == LO_A);
  end

  assign wr_hi = dec.wr_hi;

  always_comb begin
    rd_mux = '0;
    if (dec.rd_hi) rd_mux = hi_q;
    if (dec.rd_lo) rd_mux = lo_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/chg_level_counter.sv
module chg_level_counter #(
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned HI_ADDR      = 8'h03,
  parameter int unsigned LO_ADDR      = 8'h17,
  parameter int unsigned FRAC_W       = 8,
  parameter int unsigned FAST_STEP    = 243,
  parameter int unsigned TRICKLE_STEP = 192
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chg_pulse,
  input  logic              dsg_pulse,
  input  logic              sdsg_pulse,
  input  logic              valid_chg,
  input  logic              fast_sel,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rd_data,
  output logic [7:0]        hi_byte,
  output logic [7:0]        lo_byte
);
  logic wr_hi;
  logic inc;

  chg_reg_port #(
    .ADDR_W(ADDR_W), .HI_ADDR(HI_ADDR), .LO_ADDR(LO_ADDR)
  ) u_port (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .reg_addr(reg_addr), .hi_q(hi_byte), .lo_q(lo_byte),
    .wr_hi(wr_hi), .rd_data(rd_data)
  );

  chg_eff_weight #(
    .FRAC_W(FRAC_W), .FAST_STEP(FAST_STEP), .TRICKLE_STEP(TRICKLE_STEP)
  ) u_eff (
    .clk(clk), .rst(rst), .chg_pulse(chg_pulse),
    .hold(wr_hi | valid_chg), .fast_sel(fast_sel), .carry(inc)
  );

  chg_acc_core u_core (
    .clk(clk), .rst(rst), .inc(inc),
    .dsg_pulse(dsg_pulse), .sdsg_pulse(sdsg_pulse),
    .wr_hi(wr_hi), .clr_lo(valid_chg), .wdata(wdata),
    .hi_q(hi_byte), .lo_q(lo_byte)
  );
endmodule

// File: rtl/chg_level_counter_chk.sv
module chg_level_counter_chk #(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned HI_ADDR = 8'h03
) (
  input logic              clk,
  input logic              rst,
  input logic              chg_pulse,
  input logic              dsg_pulse,
  input logic              sdsg_pulse,
  input logic              valid_chg,
  input logic              wr_en,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [7:0]        wdata,
  input logic [7:0]        hi_byte,
  input logic [7:0]        lo_byte
);
  logic wr_h;
  assign wr_h = wr_en && (reg_addr == HI_ADDR[ADDR_W-1:0]);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (hi_byte == 8'h00 && lo_byte == 8'h00)); // R1

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    wr_h |=> hi_byte == $past(wdata)); // R9

  AST_VALID_CLEARS_LO: assert property (@(posedge clk) disable iff (rst)
    valid_chg |=> lo_byte == 8'h00); // R7

  AST_LO_FROZEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (hi_byte == 8'h00 && !chg_pulse && !wr_h && !valid_chg)
      |=> ($stable(lo_byte) && hi_byte == 8'h00)); // R6

  AST_NO_WRAP_UP: assert property (@(posedge clk) disable iff (rst)
    ({hi_byte, lo_byte} == 16'hFFFF && !dsg_pulse && !sdsg_pulse && !wr_h && !valid_chg)
      |=> {hi_byte, lo_byte} == 16'hFFFF); // R8

  AST_NO_RISE_WITHOUT_CHARGE: assert property (@(posedge clk) disable iff (rst)
    (!chg_pulse && !wr_h && !valid_chg)
      |=> {hi_byte, lo_byte} <= $past({hi_byte, lo_byte})); // R2
endmodule

bind chg_level_counter chg_level_counter_chk #(
  .ADDR_W(ADDR_W), .HI_ADDR(HI_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .chg_pulse(chg_pulse), .dsg_pulse(dsg_pulse),
  .sdsg_pulse(sdsg_pulse), .valid_chg(valid_chg), .wr_en(wr_en),
  .reg_addr(reg_addr), .wdata(wdata), .hi_byte(hi_byte), .lo_byte(lo_byte)
);

// File: tb/chg_level_counter_test.sv
`timescale 1ns/1ps
module chg_level_counter_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chg_pulse = 1'b0, dsg_pulse = 1'b0, sdsg_pulse = 1'b0;
  logic valid_chg = 1'b0, fast_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] reg_addr = 8'h00, wdata = 8'h00;
  logic [7:0] rd_data, hi_byte, lo_byte;

  always #2.5 clk = ~clk;

  chg_level_counter uut (
    .clk(clk), .rst(rst), .chg_pulse(chg_pulse), .dsg_pulse(dsg_pulse),
    .sdsg_pulse(sdsg_pulse), .valid_chg(valid_chg), .fast_sel(fast_sel),
    .wr_en(wr_en), .rd_en(rd_en), .reg_addr(reg_addr), .wdata(wdata),
    .rd_data(rd_data), .hi_byte(hi_byte), .lo_byte(lo_byte)
  );

  typedef struct {
    logic [15:0] cnt;
    logic [7:0]  rd;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;

  logic [15:0] m_cnt = 16'h0;
  logic [7:0]  m_frac = 8'h0;
  logic [7:0]  m_rd = 8'h0;

  task automatic step(input logic r, input logic c, input logic d, input logic s,
                      input logic v, input logic f, input logic w, input logic rd,
                      input logic [7:0] a, input logic [7:0] wd, input string tag);
    item_t it;
    logic [8:0] sum;
    logic inc;
    int dec;
    @(negedge clk);
    rst = r; chg_pulse = c; dsg_pulse = d; sdsg_pulse = s; valid_chg = v;
    fast_sel = f; wr_en = w; rd_en = rd; reg_addr = a; wdata = wd;
    if (r) begin
      m_cnt = 16'h0; m_frac = 8'h0; m_rd = 8'h0;
    end else begin
      if (rd) m_rd = (a == 8'h03) ? m_cnt[15:8] : (a == 8'h17) ? m_cnt[7:0] : 8'h00;
      if ((w && a == 8'h03) || v) begin
        if (w && a == 8'h03) m_cnt[15:8] = wd;
        if (v) m_cnt[7:0] = 8'h00;
      end else begin
        inc = 1'b0;
        if (c) begin
          sum = {1'b0, m_frac} + (f ? 9'd243 : 9'd192);
          inc = sum[8];
          m_frac = sum[7:0];
        end
        dec = (m_cnt[15:8] == 8'h00) ? 0 : (int'(d) + int'(s));
        if (inc && m_cnt != 16'hFFFF) m_cnt = m_cnt + 16'd1;
        m_cnt = m_cnt - 16'(dec);
      end
    end
    it.cnt = m_cnt; it.rd = m_rd; it.tag = tag;
    q.push_back(it);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if ({hi_byte, lo_byte} !== it.cnt) begin
        errors++;
        $display("FAIL %s count: actual %h expected %h", it.tag, {hi_byte, lo_byte}, it.cnt);
      end
      checks++;
      if (rd_data !== it.rd) begin
        errors++;
        $display("FAIL %s rd_data: actual %h expected %h", it.tag, rd_data, it.rd);
      end
    end
  end

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 8'h00, 8'h00, tag);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(1, 0, 0, 0, 0, 0, 0, 0, 8'h00, 8'h00, "R1");
    step(1, 1, 1, 0, 0, 1, 0, 1, 8'h03, 8'h00, "R1");
    step(0, 0, 0, 0, 0, 0, 0, 1, 8'h03, 8'h00, "R1 read hi");
    step(0, 0, 0, 0, 0, 0, 0, 1, 8'h17, 8'h00, "R1 read lo");
    // R6: discharge with empty high byte is ignored
    step(0, 0, 1, 1, 0, 0, 0, 0, 8'h00, 8'h00, "R6 empty");
    // R3 trickle weighting
    for (int i = 0; i < 9; i++) step(0, 1, 0, 0, 0, 0, 0, 0, 8'h00, 8'h00, "R3 trickle");
    // R3 fast weighting
    for (int i = 0; i < 30; i++) step(0, 1, 0, 0, 0, 1, 0, 0, 8'h00, 8'h00, "R3 fast");
    // R6 lo frozen with pulses while hi zero, charge still counts
    step(0, 1, 1, 1, 0, 1, 0, 0, 8'h00, 8'h00, "R6 charge while empty");
    // R4 write high byte, R9 pulses dropped in same cycle
    step(0, 0, 0, 0, 0, 0, 1, 0, 8'h03, 8'h02, "R4 write hi");
    step(0, 1, 1, 1, 0, 1, 1, 0, 8'h03, 8'h05, "R9 write beats pulses");
    step(0, 0, 0, 0, 0, 0, 0, 1, 8'h03, 8'h00, "R10 read hi");
    step(0, 0, 0, 0, 0, 0, 0, 1, 8'h17, 8'h00, "R10 read lo");
    // R5 write to low byte address has no effect
    step(0, 0, 0, 0, 0, 0, 1, 0, 8'h17, 8'hAA, "R5 lo write ignored");
    step(0, 0, 0, 0, 0, 0, 0, 1, 8'h17, 8'h00, "R5 read lo");
    // R2 discharge single, self-discharge single, both
    step(0, 0, 1, 0, 0, 0, 0, 0, 8'h00, 8'h00, "R2 dsg");
    step(0, 0, 0, 1, 0, 0, 0, 0, 8'h00, 8'h00, "R2 sdsg");
    step(0, 0, 1, 1, 0, 0, 0, 0, 8'h00, 8'h00, "R2 both");
    for (int i = 0; i < 40; i++) step(0, 0, 1, 1, 0, 0, 0, 0, 8'h00, 8'h00, "R2 borrow");
    // R7 valid charge clears low byte, R9 pulses dropped
    step(0, 1, 1, 0, 1, 1, 0, 0, 8'h00, 8'h00, "R7 valid charge");
    step(0, 0, 0, 0, 0, 0, 0, 1, 8'h03, 8'h00, "R7 hi kept");
    // R10 unknown address and hold without rd_en
    step(0, 0, 0, 0, 0, 0, 0, 1, 8'h04, 8'h00, "R10 other addr");
    step(0, 0, 0, 0, 0, 0, 0, 1, 8'h03, 8'h00, "R10 read hi");
    step(0, 0, 0, 0, 0, 0, 0, 0, 8'h17, 8'h00, "R10 hold");
    // R8 saturation
    step(0, 0, 0, 0, 0, 0, 1, 0, 8'h03, 8'hFF, "R8 preset");
    for (int i = 0; i < 300; i++) step(0, 1, 0, 0, 0, 1, 0, 0, 8'h00, 8'h00, "R8 saturate");
    step(0, 1, 1, 0, 0, 1, 0, 0, 8'h00, 8'h00, "R8 dec at max");
    // R6 nonzero low byte frozen with empty high byte
    step(0, 0, 0, 0, 0, 0, 1, 0, 8'h03, 8'h00, "R6 empty hi");
    for (int i = 0; i < 4; i++) step(0, 0, 1, 1, 0, 0, 0, 0, 8'h00, 8'h00, "R6 frozen");
    step(0, 0, 0, 0, 0, 0, 0, 1, 8'h17, 8'h00, "R6 read lo");
    // R1 reset again from nonzero state
    step(1, 0, 0, 0, 0, 0, 0, 0, 8'h00, 8'h00, "R1 re-reset");
    idle("R1 after reset");
    idle("idle");
    @(negedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule